// File: doc/BRIEF.md
# NCO Phase Accumulator Controller

This block produces the phase word that drives a sine/cosine generator in a direct digital synthesiser. A wide accumulator advances by a programmable step on every enabled clock and wraps around modulo its full range. A programmable phase offset is added to the accumulated phase, and the top bits of the sum go downstream. The remaining bits only carry fractional phase, which gives fine frequency resolution. The step can be rewritten on every cycle, so the phase stays continuous while the frequency is modulated.

One shared data port loads three wide registers: the phase step, the phase offset and an absolute jump target. Each register is written in two halves. A low-half strobe fills a holding register. A high-half strobe then commits the complete word to the register picked by the select input, so the update is atomic.

Two commands reshape the phase trajectory. A restart clears the phase state. A jump loads the jump target into the accumulator. Both act at the head of a fixed-latency output pipeline, so every sample already in flight leaves the pipeline unchanged before the discontinuity shows. A valid flag travels alongside each sample. Clock enable freezes the whole block.

Top module: `nco_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, `phase_out` is 0, `phase_vld` is 0, and the step, offset, jump target, holding register and accumulator are all cleared.
- R2: On an enabled edge, `wr_lo` stores `din` in the holding register. On the same edge, `wr_hi` commits {`din`, holding value from before the edge} (din forms bits 33:17) to a register chosen by `sel`: 0 selects the step, 1 the offset and 2 the jump target. Value 3 writes nothing.
- R3: On each enabled edge without a command, the accumulator adds the step from before the edge, modulo 2^34, wrapping through zero.
- R4: Each enabled edge launches a sample equal to bits 33:18 of (accumulator + offset) mod 2^34, both taken before the edge. The sample reaches `phase_out` after LAT (default 31) enabled edges, counting the launching edge.
- R5: With a step of zero, the accumulator holds and successive output samples are identical.
- R6: A step committed on edge k is first added on edge k+1, and the accumulator carries over without a reset, so the phase stays continuous.
- R7: `jump` loads the jump target from before the edge into the accumulator in place of the addition. The sample launched on that edge still uses the old accumulator, and a step committed on the same edge does not affect this load.
- R8: `restart` clears the accumulator, step and offset, and invalidates output. It overrides `jump` and both write strobes on the same edge. Samples already launched drain unchanged.
- R9: Each sample carries a valid tag equal to a run flag from before the launching edge. The run flag is set by a step commit (`sel`=0) and cleared by `restart` or `rst_n`.
- R10: With `cen` low, no register changes, and strobes and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen | input | 1 | Clock enable for every register |
| sel | input | 2 | Commit target: 0 step, 1 offset, 2 jump target, 3 none |
| wr_lo | input | 1 | Store din in holding register |
| wr_hi | input | 1 | Commit {din, holding} to selected register |
| din | input | 17 | Shared data half-word |
| restart | input | 1 | Clear phase state and invalidate |
| jump | input | 1 | Load jump target into accumulator |
| phase_out | output | 16 | Truncated phase word to sine/cosine stage |
| phase_vld | output | 1 | Valid tag for phase_out |

## Verification
The case that needs care is a command arriving on the same edge as a register commit. A jump together with a step commit must load the target while the new step waits one edge. A restart together with a jump and both strobes must override all three. Directed cycles drive each pairing on purpose, and the random phase produces many more by setting strobes and commands independently. Every cycle, the outputs are compared with a reference model that orders these effects as the requirements state. A wrong priority therefore shows up LAT cycles later as a wrong phase word or valid flag.

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl #(
  parameter int ACC_W = 34,
  parameter int OUT_W = 16,
  parameter int LAT   = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cen,
  input  logic [1:0]         sel,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [ACC_W/2-1:0] din,
  input  logic               restart,
  input  logic               jump,
  output logic [OUT_W-1:0]   phase_out,
  output logic               phase_vld
);
  localparam int HW = ACC_W / 2;

  logic [HW-1:0]    hold_q;
  logic [ACC_W-1:0] inc_q, ofs_q, jmp_q, acc_q;
  logic             run_q;
  logic [ACC_W-1:0] word, sum;
  logic [OUT_W:0]   pipe_q [LAT];

  assign word = {din, hold_q};
  assign sum  = acc_q + ofs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q <= '0;
      inc_q  <= '0;
      ofs_q  <= '0;
      jmp_q  <= '0;
      acc_q  <= '0;
      run_q  <= 1'b0;
    end else if (cen) begin
      if (restart) begin
        acc_q <= '0;
        inc_q <= '0;
        ofs_q <= '0;
        run_q <= 1'b0;
      end else begin
        acc_q <= jump ? jmp_q : acc_q + inc_q;
        if (wr_lo) hold_q <= din;
        if (wr_hi)
          case (sel)
            2'd0: begin inc_q <= word; run_q <= 1'b1; end
            2'd1: ofs_q <= word;
            2'd2: jmp_q <= word;
            default: ;
          endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe_q[0] <= '0;
    else if (cen) pipe_q[0] <= {run_q, sum[ACC_W-1 -: OUT_W]};

  for (genvar i = 1; i < LAT; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe_q[i] <= '0;
      else if (cen) pipe_q[i] <= pipe_q[i-1];
  end

  assign phase_out = pipe_q[LAT-1][OUT_W-1:0];
  assign phase_vld = pipe_q[LAT-1][OUT_W];

  p_zero_inc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && inc_q == '0 && !jump && !restart) |=> $stable(acc_q));

  p_jump_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && jump && !restart) |=> acc_q == $past(jmp_q));

  p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && restart) |=> (acc_q == '0 && inc_q == '0 && ofs_q == '0 && !run_q));

  p_cen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |=> ($stable(phase_out) && $stable(phase_vld) && $stable(acc_q)));

  p_sel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && wr_hi && sel == 2'd3 && !restart) |=> ($stable(inc_q) && $stable(ofs_q) && $stable(jmp_q)));
endmodule

// File: tb/nco_phase_ctrl_tb.sv
module nco_phase_ctrl_tb;
  localparam int LAT = 31;

  logic clk = 0, rst_n = 0, cen = 0, wr_lo = 0, wr_hi = 0, restart = 0, jump = 0;
  logic [1:0]  sel = 0;
  logic [16:0] din = 0;
  logic [15:0] phase_out;
  logic        phase_vld;

  int nchk = 0, nfail = 0;
  string cur = "R4";

  nco_phase_ctrl u_dut (.clk, .rst_n, .cen, .sel, .wr_lo, .wr_hi, .din,
                        .restart, .jump, .phase_out, .phase_vld);

  always #5 clk = ~clk;

  logic [33:0] m_acc, m_inc, m_ofs, m_jmp;
  logic [16:0] m_hold;
  logic        m_run;
  logic [16:0] m_pipe [LAT];

  function automatic logic [15:0] trunc_phase(logic [33:0] a, logic [33:0] o);
    logic [33:0] s;
    s = a + o;
    return s[33:18];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_acc = 0; m_inc = 0; m_ofs = 0; m_jmp = 0; m_hold = 0; m_run = 0;
    for (int i = 0; i < LAT; i++) m_pipe[i] = 0;
  endtask

  task automatic model_edge();
    logic [33:0] w;
    if (!cen) return;
    for (int i = LAT - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
    m_pipe[0] = {m_run, trunc_phase(m_acc, m_ofs)};
    w = {din, m_hold};
    if (restart) begin
      m_acc = 0; m_inc = 0; m_ofs = 0; m_run = 0;
    end else begin
      m_acc = jump ? m_jmp : m_acc + m_inc;
      if (wr_hi)
        case (sel)
          2'd0: begin m_inc = w; m_run = 1; end
          2'd1: m_ofs = w;
          2'd2: m_jmp = w;
          default: ;
        endcase
      if (wr_lo) m_hold = din;
    end
  endtask

  task automatic step(logic c, logic [1:0] s, logic lo, logic hi, logic [16:0] d,
                      logic rs, logic jp);
    cen = c; sel = s; wr_lo = lo; wr_hi = hi; din = d; restart = rs; jump = jp;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(cur, 32'(phase_out), 32'(m_pipe[LAT-1][15:0]), "phase_out");
    chk("R9", 32'(phase_vld), 32'(m_pipe[LAT-1][16]), "phase_vld");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 3, 0, 0, 0, 0, 0);
  endtask

  task automatic write34(logic [1:0] s, logic [33:0] v);
    step(1, s, 1, 0, v[16:0], 0, 0);
    step(1, s, 0, 1, v[33:17], 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5EED1234));
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1", 32'(phase_out), 0, "phase_out in reset");
    chk("R1", 32'(phase_vld), 0, "phase_vld in reset");
    rst_n = 1;

    cur = "R2"; write34(0, 34'h0_1234_5678);
    cur = "R4"; idle(LAT + 10);
    cur = "R2"; write34(1, 34'h2_0000_0001);
    cur = "R4"; idle(LAT + 4);

    cur = "R5"; write34(0, 0);
    idle(LAT + 2);
    held = phase_out;
    idle(6);
    chk("R5", 32'(phase_out), 32'(held), "zero step holds phase");

    cur = "R3"; write34(1, 0); write34(0, 34'h3_0000_0000);
    idle(LAT + 12);

    cur = "R6";
    for (int i = 0; i < 120; i++) step(1, 0, 0, 1, 17'($urandom), 0, 0);
    idle(LAT);

    cur = "R7"; write34(2, 34'h1_5555_AAAA);
    step(1, 0, 0, 1, 17'h00100, 0, 1);
    idle(LAT + 3);

    cur = "R8";
    step(1, 2, 1, 1, 17'h1FFFF, 1, 1);
    idle(3);
    write34(0, 34'h0_0400_0000);
    idle(LAT + 3);

    cur = "R10";
    for (int i = 0; i < 40; i++)
      step(0, 2'($urandom), 1'($urandom), 1'($urandom), 17'($urandom),
           1'($urandom), 1'($urandom));
    idle(LAT + 2);

    cur = "R4";
    for (int i = 0; i < 4000; i++)
      step(($urandom % 8) != 0, 2'($urandom), 1'($urandom), ($urandom % 3) == 0,
           17'($urandom), ($urandom % 97) == 0, ($urandom % 29) == 0);
    idle(LAT);

    rst_n = 0;
    model_clear();
    @(negedge clk);
    chk("R1", 32'(phase_out), 0, "phase_out after late reset");
    chk("R1", 32'(phase_vld), 0, "phase_vld after late reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule